// File: doc/BRIEF.md
# Dual-Pin Latched Interrupt Controller

The controller turns four event sources into sticky status bits and drives two interrupt pins from them. Three sources come from outside as level signals: sync-measurement valid, lock gained and lock lost. Each of these passes through a rising-edge detector. The fourth source is a software-forced event that the host raises through a stimulus register. A status bit stays set until the host writes a 1 to its bit in the matching clear register.

Two independent mask sets, A and B, decide which sources reach each pin. Each pin is the registered OR of the status bits enabled in its mask set. By default a status bit can only latch when its source is enabled in at least one mask set. A global keep-masked option lets every event latch its status bit whatever the masks hold. The pins still ignore masked sources, so the host can poll such events without taking an interrupt.

The host reaches the block through an 8-bit address, write data and read data port with a write strobe. Reads are combinational.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, every status bit, every mask bit and the keep-masked bit are 0, and both pins are low.
- R2: A set status bit stays set until a 1 is written to its clear bit. Writing 0 to a clear bit, or a 1 to a different clear bit, leaves it set.
- R3: When keep-masked is 0, an event sets its status bit only if its mask A bit or its mask B bit is 1.
- R4: When keep-masked (CFG 0x00 bit 0) is 1, any event sets its status bit whatever the mask bits are.
- R5: A status bit that latched while both of its mask bits were 0 does not raise either pin.
- R6: Pin A (B) goes high one clock after any status bit that is enabled in mask A (B) is set, and goes low one clock after none is. The two pins are independent.
- R7: If a clear and a new event hit the same bit in the same cycle, the bit stays set. After a clear, a new event sets the bit again and raises the pin again.
- R8: Writing 1 to bit 7 of STIM (0x1C) creates one forced event on status bit 7 of STAT1. Writing 0 to that bit creates no event.
- R9: An input held high sets its status bit only once, on its rising edge. A clear while the input stays high is not undone until a new rising edge.
- R10: The register map is as follows. CFG is at 0x00. STAT0 is at 0x10, read-only: lock at bit 2, unlock at bit 3, measurement-valid at bit 4. CLR0 is at 0x11. MSKA0 is at 0x12 and MSKB0 at 0x13, with the same bit positions as STAT0. STAT1 is at 0x18, read-only: forced event at bit 7. CLR1 is at 0x19, MSKA1 at 0x1A, MSKB1 at 0x1B and STIM at 0x1C, all using bit 7. Clear and stimulus addresses, unmapped addresses and unused bits read 0. Writes to status addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| meas_valid_i | input | 1 | Sync-measurement-valid level |
| lock_i | input | 1 | Lock-gained level |
| unlock_i | input | 1 | Lock-lost level |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Write strobe, one write per cycle |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| irq_a_o | output | 1 | Interrupt pin A, active high level |
| irq_b_o | output | 1 | Interrupt pin B, active high level |

## Verification
The hardest case to reach is a clear and a fresh rising edge landing on the same bit in the same clock. The bench drives the clear write and the input edge from the same falling edge, so both meet at one rising edge. It then reads the status back. A second hard case is a status bit that latched under keep-masked while its pins stayed silent. The bench observes the pins for several cycles, then enables the mask to show the latched bit was real. It also holds an input high across a clear, which shows that the edge detector does not set the bit again.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int unsigned NUM_SRC   = 4;
  localparam int unsigned NUM_EXT   = 3;
  localparam int unsigned SRC_LOCK  = 0;
  localparam int unsigned SRC_ULCK  = 1;
  localparam int unsigned SRC_MEAS  = 2;
  localparam int unsigned SRC_FORCE = 3;
  // group 0 fields occupy bits [G0_LSB +: G0_NUM], group 1 uses bit G1_BIT
  localparam int unsigned G0_LSB = 2;
  localparam int unsigned G0_NUM = 3;
  localparam int unsigned G1_BIT = 7;

  localparam logic [7:0] ADDR_CFG   = 8'h00;
  localparam logic [7:0] ADDR_STAT0 = 8'h10;
  localparam logic [7:0] ADDR_CLR0  = 8'h11;
  localparam logic [7:0] ADDR_MSKA0 = 8'h12;
  localparam logic [7:0] ADDR_MSKB0 = 8'h13;
  localparam logic [7:0] ADDR_STAT1 = 8'h18;
  localparam logic [7:0] ADDR_CLR1  = 8'h19;
  localparam logic [7:0] ADDR_MSKA1 = 8'h1A;
  localparam logic [7:0] ADDR_MSKB1 = 8'h1B;
  localparam logic [7:0] ADDR_STIM  = 8'h1C;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned NUM  = 3,
  parameter bit          EDGE = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] lvl_i,
  output logic [NUM-1:0] pulse_o
);
  generate
    if (EDGE) begin : g_edge
      logic [NUM-1:0] prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= lvl_i;
      end
      assign pulse_o = lvl_i & ~prev_q;

      for (genvar i = 0; i < NUM; i++) begin : g_chk
        assert_single_pulse_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
          pulse_o[i] |=> !pulse_o[i]);
      end
    end else begin : g_pass
      assign pulse_o = lvl_i;
    end
  endgenerate
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_latch_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  src_vec_t      status_i,
  output logic          keep_masked_o,
  output src_vec_t      mask_a_o,
  output src_vec_t      mask_b_o,
  output src_vec_t      clr_o,
  output logic          force_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned G1_IDX = NUM_SRC - 1;

  logic     keep_q;
  src_vec_t mask_a_q, mask_b_q;

  logic wr_cfg, wr_clr0, wr_clr1, wr_ma0, wr_mb0, wr_ma1, wr_mb1, wr_stim;

  always_comb begin
    wr_cfg  = we_i && (addr_i == AW'(ADDR_CFG));
    wr_clr0 = we_i && (addr_i == AW'(ADDR_CLR0));
    wr_clr1 = we_i && (addr_i == AW'(ADDR_CLR1));
    wr_ma0  = we_i && (addr_i == AW'(ADDR_MSKA0));
    wr_mb0  = we_i && (addr_i == AW'(ADDR_MSKB0));
    wr_ma1  = we_i && (addr_i == AW'(ADDR_MSKA1));
    wr_mb1  = we_i && (addr_i == AW'(ADDR_MSKB1));
    wr_stim = we_i && (addr_i == AW'(ADDR_STIM));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_q   <= 1'b0;
      mask_a_q <= '0;
      mask_b_q <= '0;
    end else begin
      if (wr_cfg) keep_q <= wdata_i[0];
      if (wr_ma0) mask_a_q[G0_NUM-1:0] <= wdata_i[G0_LSB +: G0_NUM];
      if (wr_mb0) mask_b_q[G0_NUM-1:0] <= wdata_i[G0_LSB +: G0_NUM];
      if (wr_ma1) mask_a_q[G1_IDX] <= wdata_i[G1_BIT];
      if (wr_mb1) mask_b_q[G1_IDX] <= wdata_i[G1_BIT];
    end
  end

  // clear and stimulus are strobes: present only in the write cycle
  always_comb begin
    clr_o[G0_NUM-1:0] = {G0_NUM{wr_clr0}} & wdata_i[G0_LSB +: G0_NUM];
    clr_o[G1_IDX]     = wr_clr1 & wdata_i[G1_BIT];
    force_o           = wr_stim & wdata_i[G1_BIT];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(ADDR_CFG):   rdata_o[0] = keep_q;
      AW'(ADDR_STAT0): rdata_o[G0_LSB +: G0_NUM] = status_i[G0_NUM-1:0];
      AW'(ADDR_MSKA0): rdata_o[G0_LSB +: G0_NUM] = mask_a_q[G0_NUM-1:0];
      AW'(ADDR_MSKB0): rdata_o[G0_LSB +: G0_NUM] = mask_b_q[G0_NUM-1:0];
      AW'(ADDR_STAT1): rdata_o[G1_BIT] = status_i[G1_IDX];
      AW'(ADDR_MSKA1): rdata_o[G1_BIT] = mask_a_q[G1_IDX];
      AW'(ADDR_MSKB1): rdata_o[G1_BIT] = mask_b_q[G1_IDX];
      default:         rdata_o = '0;
    endcase
  end

  assign keep_masked_o = keep_q;
  assign mask_a_o      = mask_a_q;
  assign mask_b_o      = mask_b_q;

  assert_cfg_hold_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg |=> $stable(keep_q));
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core
  import irq_latch_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t evt_i,
  input  src_vec_t clr_i,
  input  logic     keep_masked_i,
  input  src_vec_t mask_a_i,
  input  src_vec_t mask_b_i,
  output src_vec_t status_o,
  output logic     irq_a_o,
  output logic     irq_b_o
);
  src_vec_t st_q;
  logic     irq_a_q, irq_b_q;

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic allow;
      assign allow = keep_masked_i | mask_a_i[i] | mask_b_i[i];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 st_q[i] <= 1'b0;
        else if (evt_i[i] && allow)  st_q[i] <= 1'b1;  // new event beats clear
        else if (clr_i[i])           st_q[i] <= 1'b0;
      end

      assert_sticky_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q[i] && !clr_i[i] |=> st_q[i]);
      assert_gate_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !keep_masked_i && !mask_a_i[i] && !mask_b_i[i] && !st_q[i] |=> !st_q[i]);
      assert_keep_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        keep_masked_i && evt_i[i] |=> st_q[i]);
      assert_race_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[i] && clr_i[i] && (mask_a_i[i] || mask_b_i[i]) |=> st_q[i]);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_a_q <= 1'b0;
      irq_b_q <= 1'b0;
    end else begin
      irq_a_q <= |(st_q & mask_a_i);
      irq_b_q <= |(st_q & mask_b_i);
    end
  end

  assign status_o = st_q;
  assign irq_a_o  = irq_a_q;
  assign irq_b_o  = irq_b_q;

  assert_pin_a_quiet_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q & mask_a_i) == '0) |=> !irq_a_q);
  assert_pin_b_quiet_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q & mask_b_i) == '0) |=> !irq_b_q);
  assert_pin_a_rise_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q & mask_a_i) != '0) |=> irq_a_q);
  assert_pin_b_rise_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q & mask_b_i) != '0) |=> irq_b_q);
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 8,
  parameter bit          EDGE_IN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          meas_valid_i,
  input  logic          lock_i,
  input  logic          unlock_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  input  logic          reg_we_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_a_o,
  output logic          irq_b_o
);
  logic [NUM_EXT-1:0] ext_lvl, ext_pulse;
  src_vec_t evt, clr, mask_a, mask_b, status;
  logic     keep_masked, force_evt;

  always_comb begin
    ext_lvl           = '0;
    ext_lvl[SRC_LOCK] = lock_i;
    ext_lvl[SRC_ULCK] = unlock_i;
    ext_lvl[SRC_MEAS] = meas_valid_i;
  end

  irq_edge_detect #(.NUM(NUM_EXT), .EDGE(EDGE_IN)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (ext_lvl),
    .pulse_o (ext_pulse)
  );

  always_comb begin
    evt                = '0;
    evt[NUM_EXT-1:0]   = ext_pulse;
    evt[SRC_FORCE]     = force_evt;
  end

  irq_reg_file #(.AW(AW), .DW(DW)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .we_i          (reg_we_i),
    .status_i      (status),
    .keep_masked_o (keep_masked),
    .mask_a_o      (mask_a),
    .mask_b_o      (mask_b),
    .clr_o         (clr),
    .force_o       (force_evt),
    .rdata_o       (reg_rdata_o)
  );

  irq_status_core u_core (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .evt_i         (evt),
    .clr_i         (clr),
    .keep_masked_i (keep_masked),
    .mask_a_i      (mask_a),
    .mask_b_i      (mask_b),
    .status_o      (status),
    .irq_a_o       (irq_a_o),
    .irq_b_o       (irq_b_o)
  );

  assert_force_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_evt && (mask_a[SRC_FORCE] || mask_b[SRC_FORCE] || keep_masked) |=> status[SRC_FORCE]);
endmodule

// File: tb/irq_latch_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_latch_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       meas = 1'b0, lock = 1'b0, ulck = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic       irq_a, irq_b;
  int         n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_latch_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .meas_valid_i(meas), .lock_i(lock), .unlock_i(ulck),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_we_i(we),
    .reg_rdata_o(rdata), .irq_a_o(irq_a), .irq_b_o(irq_b)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
    addr = a; #0.5;
    check(req, rdata, exp);
  endtask

  // rising edge held one cycle; status set at the enclosed posedge
  task automatic pulse(input int which);
    @(negedge clk);
    case (which) 0: lock = 1; 1: ulck = 1; default: meas = 1; endcase
    @(negedge clk);
    lock = 0; ulck = 0; meas = 0;
  endtask

  task automatic t_reset();
    rd_chk("R1 cfg", 8'h00, 0);
    rd_chk("R1 stat0", 8'h10, 0);
    rd_chk("R1 stat1", 8'h18, 0);
    rd_chk("R1 mska0", 8'h12, 0);
    rd_chk("R1 mskb1", 8'h1B, 0);
    check("R1 irq_a", irq_a, 0);
    check("R1 irq_b", irq_b, 0);
  endtask

  task automatic t_gate_sticky();
    pulse(0);
    rd_chk("R3 masked lock ignored", 8'h10, 0);
    wr(8'h13, 8'h04);
    pulse(0);
    rd_chk("R3 enabled lock sets", 8'h10, 8'h04);
    @(negedge clk);
    check("R6 irq_b high", irq_b, 1);
    check("R6 irq_a low", irq_a, 0);
    repeat (4) @(negedge clk);
    wr(8'h11, 8'h00);
    rd_chk("R2 clear zero keeps", 8'h10, 8'h04);
    wr(8'h11, 8'h18);
    rd_chk("R2 other clear keeps", 8'h10, 8'h04);
    wr(8'h11, 8'h04);
    rd_chk("R2 clear works", 8'h10, 0);
    @(negedge clk);
    check("R6 irq_b drops", irq_b, 0);
    wr(8'h13, 8'h00);
  endtask

  task automatic t_keep();
    wr(8'h00, 8'h01);
    rd_chk("R4 cfg readback", 8'h00, 1);
    pulse(1);
    pulse(2);
    rd_chk("R4 unmasked latch", 8'h10, 8'h18);
    repeat (3) begin
      @(negedge clk);
      check("R5 irq_a quiet", irq_a, 0);
      check("R5 irq_b quiet", irq_b, 0);
    end
    wr(8'h12, 8'h08);
    @(negedge clk);
    check("R6 late mask raises a", irq_a, 1);
    wr(8'h12, 8'h00);
    wr(8'h11, 8'h1C);
    rd_chk("R4 cleared", 8'h10, 0);
    wr(8'h00, 8'h00);
  endtask

  task automatic t_force();
    wr(8'h1A, 8'h80);
    wr(8'h1C, 8'h7F);
    rd_chk("R8 stim bit clear no event", 8'h18, 0);
    wr(8'h1C, 8'h80);
    rd_chk("R8 forced event", 8'h18, 8'h80);
    @(negedge clk);
    check("R8 irq_a forced", irq_a, 1);
    check("R6 irq_b idle", irq_b, 0);
    wr(8'h19, 8'h80);
    rd_chk("R8 forced cleared", 8'h18, 0);
    wr(8'h1A, 8'h00);
  endtask

  task automatic t_race();
    wr(8'h12, 8'h04);
    pulse(0);
    rd_chk("R7 set", 8'h10, 8'h04);
    @(negedge clk); lock = 1; addr = 8'h11; wdata = 8'h04; we = 1;
    @(negedge clk); lock = 0; we = 0;
    rd_chk("R7 event beats clear", 8'h10, 8'h04);
    wr(8'h11, 8'h04);
    rd_chk("R7 cleared", 8'h10, 0);
    @(negedge clk);
    check("R7 pin low after clear", irq_a, 0);
    pulse(0);
    rd_chk("R7 re-set", 8'h10, 8'h04);
    @(negedge clk);
    check("R7 pin re-raised", irq_a, 1);
    wr(8'h11, 8'h04);
    wr(8'h12, 8'h00);
  endtask

  task automatic t_level();
    wr(8'h12, 8'h10);
    @(negedge clk); meas = 1;
    repeat (3) @(negedge clk);
    rd_chk("R9 held sets", 8'h10, 8'h10);
    wr(8'h11, 8'h10);
    repeat (3) @(negedge clk);
    rd_chk("R9 held no re-set", 8'h10, 0);
    meas = 0;
    pulse(2);
    rd_chk("R9 new edge sets", 8'h10, 8'h10);
    wr(8'h11, 8'h10);
    wr(8'h12, 8'h00);
  endtask

  task automatic t_pins();
    wr(8'h12, 8'h04);
    wr(8'h13, 8'h08);
    pulse(1);
    @(negedge clk);
    check("R6 b only", irq_b, 1);
    check("R6 a stays low", irq_a, 0);
    pulse(0);
    @(negedge clk);
    check("R6 a now high", irq_a, 1);
    wr(8'h11, 8'h0C);
    wr(8'h12, 8'h00);
    wr(8'h13, 8'h00);
  endtask

  task automatic t_map();
    wr(8'h12, 8'h04);
    pulse(0);
    wr(8'h10, 8'h00);
    rd_chk("R10 stat ro", 8'h10, 8'h04);
    wr(8'h18, 8'hFF);
    rd_chk("R10 stat1 ro", 8'h18, 0);
    wr(8'h11, 8'h04);
    wr(8'h12, 8'h00);
    wr(8'h13, 8'hFF);
    rd_chk("R10 mask field bits", 8'h13, 8'h1C);
    wr(8'h1B, 8'hFF);
    rd_chk("R10 mask1 bit7", 8'h1B, 8'h80);
    rd_chk("R10 clr reads 0", 8'h11, 0);
    rd_chk("R10 stim reads 0", 8'h1C, 0);
    wr(8'h55, 8'hFF);
    rd_chk("R10 unmapped 0", 8'h55, 0);
    rd_chk("R10 cfg untouched", 8'h00, 0);
    wr(8'h13, 8'h00);
    wr(8'h1B, 8'h00);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate_sticky();
    t_keep();
    t_force();
    t_race();
    t_level();
    t_pins();
    t_map();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule